// File: doc/BRIEF.md
# Dual-Width FIFO Port Adapter

This block sits between an 18-bit FIFO word path and the two data ports of a FIFO. Each port can be 18 or 9 bits wide. The widths are chosen independently while master reset is held, so all four write/read width pairs are legal. When the write port is narrow and the read port is wide, two 9-bit writes are packed into one 18-bit word before it goes to storage. When the write port is wide and the read port is narrow, each stored word is split into two 9-bit reads. A byte-order select, also captured during reset, decides which half of the word carries the first narrow item.

When both ports are narrow, no packing takes place. Each 9-bit item travels alone in the low half of a storage word.

The storage array, the flags, parity and the output drivers are outside this block. It sees only the port strobes and data, and it exchanges whole words with storage. On the storage side, storage returns `st_rd_data` with `st_rd_valid` one cycle after a request on `st_rd_req`. The read port must not strobe again until `rd_valid` has answered the previous strobe.

Top module: `fifo_width_adapter`

## Requirements
- R1: `cfg_wr_narrow`, `cfg_rd_narrow` and `cfg_little` are sampled only while `rst` is high. Changing them after reset has no effect on packing, order or width.
- R2: With a wide write port (`cfg_wr_narrow`=0), a write on `wr_en` appears one cycle later as `st_wr_en`=1, with `st_wr_data` equal to the full 18-bit `wr_data`.
- R3: With a narrow write port, a wide read port and big-endian order (`cfg_little`=0), the first write of a pair raises no `st_wr_en`. The second write raises `st_wr_en` one cycle later, with the first item in bits 17:9 and the second in bits 8:0.
- R4: In the same mode with little-endian order (`cfg_little`=1), the first item lands in bits 8:0 and the second in bits 17:9.
- R5: A first half that is still pending when reset is applied is discarded. The next two writes after reset form the next word.
- R6: With a wide read port, a read strobe raises `st_rd_req` in the same cycle. `rd_data` takes the returned word, with `rd_valid`=1 for one cycle, one cycle after `st_rd_valid`.
- R7: With a narrow read port and a wide write port, only the first read of each pair raises `st_rd_req`. The first read returns bits 17:9 in big-endian order (bits 8:0 in little-endian order) and the second read returns the other half. Bits 17:9 of `rd_data` are zero. The second read answers with `rd_valid` one cycle after its strobe.
- R8: With both ports narrow, every write stores {9'b0, `wr_data[8:0]`}. Every read requests one word and returns its bits 8:0 with bits 17:9 zero.
- R9: Reset clears `rd_data` to zero and drives `rd_valid`=0 and `st_wr_en`=0.
- R10: On a narrow write port, `wr_data[17:9]` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset; configuration is sampled while high |
| cfg_wr_narrow | input | 1 | 1 selects a 9-bit write port, 0 an 18-bit one |
| cfg_rd_narrow | input | 1 | 1 selects a 9-bit read port, 0 an 18-bit one |
| cfg_little | input | 1 | 0 big-endian (first item in high half), 1 little-endian |
| wr_en | input | 1 | Write-port strobe |
| wr_data | input | 18 | Write-port data |
| st_wr_en | output | 1 | Word write toward storage |
| st_wr_data | output | 18 | Word toward storage |
| rd_en | input | 1 | Read-port strobe |
| rd_data | output | 18 | Read-port data, registered |
| rd_valid | output | 1 | One-cycle pulse when rd_data holds a new item |
| st_rd_req | output | 1 | Request for the next stored word |
| st_rd_valid | input | 1 | Storage word valid, one cycle after the request |
| st_rd_data | input | 18 | Word from storage |

## Verification
Each width pair is run as a round trip: words are written, captured by a storage model and read back. Using both byte orders with the same data tells the two halves apart. Byte values that differ in every position, including all-ones against near-zero items, reveal swapped or truncated halves. Garbage in the unused upper write bits exposes any leak of those bits. Directed runs cover a half word left pending across reset, configuration inputs that change after reset, and two unpacked words read back to back, with the storage request count checked.

// File: rtl/fwa_pkg.sv
package fwa_pkg;

  typedef enum logic [1:0] {
    WM_WIDE = 2'd0,
    WM_PACK = 2'd1,
    WM_PASS = 2'd2
  } wr_mode_e;

  typedef enum logic [1:0] {
    RM_WIDE   = 2'd0,
    RM_UNPACK = 2'd1,
    RM_PASS   = 2'd2
  } rd_mode_e;

  typedef struct packed {
    logic wr_narrow;
    logic rd_narrow;
    logic little;
  } port_cfg_t;

  function automatic wr_mode_e wr_mode_of(port_cfg_t c);
    if (!c.wr_narrow)     return WM_WIDE;
    else if (c.rd_narrow) return WM_PASS;
    else                  return WM_PACK;
  endfunction

  function automatic rd_mode_e rd_mode_of(port_cfg_t c);
    if (!c.rd_narrow)     return RM_WIDE;
    else if (c.wr_narrow) return RM_PASS;
    else                  return RM_UNPACK;
  endfunction

endpackage

// File: rtl/fwa_cfg_latch.sv
module fwa_cfg_latch
  import fwa_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  port_cfg_t cfg_in,
  output port_cfg_t cfg_q,
  output wr_mode_e  wr_mode,
  output rd_mode_e  rd_mode
);

  // Configuration is only loaded while master reset is asserted.
  always_ff @(posedge clk) begin
    if (rst) cfg_q <= cfg_in;
  end

  assign wr_mode = wr_mode_of(cfg_q);
  assign rd_mode = rd_mode_of(cfg_q);

endmodule

// File: rtl/fwa_wr_packer.sv
module fwa_wr_packer
  import fwa_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  wr_mode_e          wr_mode,
  input  logic              little,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              st_wr_en,
  output logic [DATA_W-1:0] st_wr_data
);

  localparam int HALF_W = DATA_W / 2;

  logic              half_pending;
  logic [HALF_W-1:0] held;
  logic [HALF_W-1:0] lo_in;

  assign lo_in = wr_data[HALF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      half_pending <= 1'b0;
      held         <= '0;
      st_wr_en     <= 1'b0;
      st_wr_data   <= '0;
    end else begin
      st_wr_en <= 1'b0;
      if (wr_en) begin
        case (wr_mode)
          WM_WIDE: begin
            st_wr_en   <= 1'b1;
            st_wr_data <= wr_data;
          end
          WM_PASS: begin
            st_wr_en   <= 1'b1;
            st_wr_data <= {{HALF_W{1'b0}}, lo_in};
          end
          WM_PACK: begin
            if (!half_pending) begin
              held         <= lo_in;
              half_pending <= 1'b1;
            end else begin
              half_pending <= 1'b0;
              st_wr_en     <= 1'b1;
              st_wr_data   <= little ? {lo_in, held} : {held, lo_in};
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/fwa_rd_unpacker.sv
module fwa_rd_unpacker
  import fwa_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  rd_mode_e          rd_mode,
  input  logic              little,
  input  logic              rd_en,
  input  logic              st_rd_valid,
  input  logic [DATA_W-1:0] st_rd_data,
  output logic              st_rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  localparam int HALF_W = DATA_W / 2;

  logic              second_pending;
  logic [HALF_W-1:0] held_second;
  logic [HALF_W-1:0] word_hi;
  logic [HALF_W-1:0] word_lo;
  logic              serve_second;

  assign word_hi      = st_rd_data[DATA_W-1:HALF_W];
  assign word_lo      = st_rd_data[HALF_W-1:0];
  assign serve_second = (rd_mode == RM_UNPACK) && second_pending;
  assign st_rd_req    = rd_en && !serve_second;

  always_ff @(posedge clk) begin
    if (rst) begin
      second_pending <= 1'b0;
      held_second    <= '0;
      rd_data        <= '0;
      rd_valid       <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (st_rd_valid) begin
        rd_valid <= 1'b1;
        case (rd_mode)
          RM_WIDE:   rd_data <= st_rd_data;
          RM_PASS:   rd_data <= {{HALF_W{1'b0}}, word_lo};
          RM_UNPACK: begin
            rd_data        <= {{HALF_W{1'b0}}, little ? word_lo : word_hi};
            held_second    <= little ? word_hi : word_lo;
            second_pending <= 1'b1;
          end
          default: ;
        endcase
      end else if (rd_en && serve_second) begin
        rd_valid       <= 1'b1;
        rd_data        <= {{HALF_W{1'b0}}, held_second};
        second_pending <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/fifo_width_adapter.sv
module fifo_width_adapter
  import fwa_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_narrow,
  input  logic              cfg_rd_narrow,
  input  logic              cfg_little,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              st_wr_en,
  output logic [DATA_W-1:0] st_wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              st_rd_req,
  input  logic              st_rd_valid,
  input  logic [DATA_W-1:0] st_rd_data
);

  port_cfg_t cfg_in;
  port_cfg_t cfg_q;
  wr_mode_e  wr_mode;
  rd_mode_e  rd_mode;

  assign cfg_in = '{wr_narrow: cfg_wr_narrow, rd_narrow: cfg_rd_narrow, little: cfg_little};

  fwa_cfg_latch u_cfg (
    .clk     (clk),
    .rst     (rst),
    .cfg_in  (cfg_in),
    .cfg_q   (cfg_q),
    .wr_mode (wr_mode),
    .rd_mode (rd_mode)
  );

  fwa_wr_packer #(.DATA_W(DATA_W)) u_pack (
    .clk        (clk),
    .rst        (rst),
    .wr_mode    (wr_mode),
    .little     (cfg_q.little),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .st_wr_en   (st_wr_en),
    .st_wr_data (st_wr_data)
  );

  fwa_rd_unpacker #(.DATA_W(DATA_W)) u_unpack (
    .clk         (clk),
    .rst         (rst),
    .rd_mode     (rd_mode),
    .little      (cfg_q.little),
    .rd_en       (rd_en),
    .st_rd_valid (st_rd_valid),
    .st_rd_data  (st_rd_data),
    .st_rd_req   (st_rd_req),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid)
  );

endmodule

// File: rtl/fwa_checker.sv
module fwa_checker
  import fwa_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst,
  input port_cfg_t         cfg_q,
  input wr_mode_e          wr_mode,
  input rd_mode_e          rd_mode,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              st_wr_en,
  input logic [DATA_W-1:0] st_wr_data,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              st_rd_req,
  input logic              st_rd_valid,
  input logic [DATA_W-1:0] st_rd_data
);

  localparam int HALF_W = DATA_W / 2;

  // Own tracking of pair phases, cleared by reset (R5).
  logic half_seen;
  logic unp_pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_seen   <= 1'b0;
      unp_pending <= 1'b0;
    end else begin
      if (wr_en && wr_mode == WM_PACK) half_seen <= ~half_seen;
      if (rd_mode == RM_UNPACK) begin
        if (st_rd_valid)                unp_pending <= 1'b1;
        else if (rd_en && unp_pending)  unp_pending <= 1'b0;
      end
    end
  end

  a_r1_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(cfg_q));

  a_r2_wide_write: assert property (@(posedge clk) disable iff (rst)
    (wr_mode == WM_WIDE && wr_en) |=> (st_wr_en && st_wr_data == $past(wr_data)));

  a_r3_first_half_held: assert property (@(posedge clk) disable iff (rst)
    (wr_mode == WM_PACK && wr_en && !half_seen) |=> !st_wr_en);

  a_r3_second_half_emits: assert property (@(posedge clk) disable iff (rst)
    (wr_mode == WM_PACK && wr_en && half_seen) |=> st_wr_en);

  a_r6_wide_read: assert property (@(posedge clk) disable iff (rst)
    (rd_mode == RM_WIDE && st_rd_valid) |=> (rd_valid && rd_data == $past(st_rd_data)));

  a_r6_valid_has_cause: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ($past(st_rd_valid) || $past(rd_en)));

  a_r7_no_second_request: assert property (@(posedge clk) disable iff (rst)
    (rd_mode == RM_UNPACK && rd_en && unp_pending) |-> !st_rd_req);

  a_r7_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_mode != RM_WIDE && rd_valid) |-> (rd_data[DATA_W-1:HALF_W] == '0));

  a_r8_pass_write: assert property (@(posedge clk) disable iff (rst)
    (wr_mode == WM_PASS && wr_en) |=>
      (st_wr_en && st_wr_data == {{HALF_W{1'b0}}, $past(wr_data[HALF_W-1:0])}));

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && !rd_valid && !st_wr_en));

endmodule

bind fifo_width_adapter fwa_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_q       (cfg_q),
  .wr_mode     (wr_mode),
  .rd_mode     (rd_mode),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .st_wr_en    (st_wr_en),
  .st_wr_data  (st_wr_data),
  .rd_en       (rd_en),
  .rd_data     (rd_data),
  .rd_valid    (rd_valid),
  .st_rd_req   (st_rd_req),
  .st_rd_valid (st_rd_valid),
  .st_rd_data  (st_rd_data)
);

// File: tb/tb_fifo_width_adapter.sv
`timescale 1ns/1ps
module tb_fifo_width_adapter;

  localparam int DW = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_wr_narrow = 1'b0, cfg_rd_narrow = 1'b0, cfg_little = 1'b0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          st_wr_en;
  logic [DW-1:0] st_wr_data;
  logic          rd_en = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rd_valid;
  logic          st_rd_req;
  logic          st_rd_valid;
  logic [DW-1:0] st_rd_data;

  always #2 clk = ~clk;

  fifo_width_adapter #(.DATA_W(DW)) dut (
    .clk(clk), .rst(rst),
    .cfg_wr_narrow(cfg_wr_narrow), .cfg_rd_narrow(cfg_rd_narrow), .cfg_little(cfg_little),
    .wr_en(wr_en), .wr_data(wr_data), .st_wr_en(st_wr_en), .st_wr_data(st_wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .st_rd_req(st_rd_req), .st_rd_valid(st_rd_valid), .st_rd_data(st_rd_data)
  );

  // Storage model: one-cycle read latency.
  logic [DW-1:0] mem [0:15];
  int wp, rp, req_cnt;
  always @(posedge clk) begin
    if (rst) begin
      wp <= 0; rp <= 0; req_cnt <= 0;
      st_rd_valid <= 1'b0; st_rd_data <= '0;
    end else begin
      if (st_wr_en) begin mem[wp[3:0]] <= st_wr_data; wp <= wp + 1; end
      if (st_rd_req) begin
        st_rd_valid <= 1'b1; st_rd_data <= mem[rp[3:0]];
        rp <= rp + 1; req_cnt <= req_cnt + 1;
      end else begin
        st_rd_valid <= 1'b0;
      end
    end
  end

  typedef struct packed {
    logic          wn, rn, le;
    logic [DW-1:0] w0, w1, stored, r0, r1;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, 18'h2A5C3, 18'h00000, 18'h2A5C3, 18'h2A5C3, 18'h00000},
    '{1'b1, 1'b0, 1'b0, 18'h001A3, 18'h0005C, 18'h3465C, 18'h3465C, 18'h00000},
    '{1'b1, 1'b0, 1'b1, 18'h001A3, 18'h0005C, 18'h0B9A3, 18'h0B9A3, 18'h00000},
    '{1'b0, 1'b1, 1'b0, 18'h3465C, 18'h00000, 18'h3465C, 18'h001A3, 18'h0005C},
    '{1'b0, 1'b1, 1'b1, 18'h3465C, 18'h00000, 18'h3465C, 18'h0005C, 18'h001A3},
    '{1'b1, 1'b1, 1'b0, 18'h000F1, 18'h00000, 18'h000F1, 18'h000F1, 18'h00000},
    '{1'b1, 1'b0, 1'b0, 18'h3FE01, 18'h3FFFF, 18'h003FF, 18'h003FF, 18'h00000},
    '{1'b1, 1'b1, 1'b1, 18'h3FFFF, 18'h00000, 18'h001FF, 18'h001FF, 18'h00000}
  };

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic wn, input logic rn, input logic le);
    @(negedge clk);
    cfg_wr_narrow = wn; cfg_rd_narrow = rn; cfg_little = le;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input string req, output logic [DW-1:0] got);
    bit seen;
    seen = 1'b0;
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    for (int k = 0; k < 6; k++) begin
      if (rd_valid) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    got = rd_data;
    if (!seen) chk({req, " rd_valid"}, 18'd0, 18'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] got;
    string wtag, rtag;

    // R9: reset state
    do_reset(1'b0, 1'b0, 1'b0);
    chk("R9 rd_data", rd_data, '0);
    chk("R9 rd_valid", {17'd0, rd_valid}, '0);
    chk("R9 st_wr_en", {17'd0, st_wr_en}, '0);

    // Table walk: round trip for every mode
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      if (!v.wn)           wtag = "R2";
      else if (v.rn)       wtag = "R8";
      else if (v.le)       wtag = "R4";
      else                 wtag = "R3";
      if (i == 6)          wtag = "R10";
      if (!v.rn)           rtag = "R6";
      else if (v.wn)       rtag = "R8";
      else                 rtag = "R7";

      do_reset(v.wn, v.rn, v.le);
      wr(v.w0);
      if (v.wn && !v.rn) begin
        chk({wtag, " first half held"}, {17'd0, st_wr_en}, 18'd0);
        wr(v.w1);
      end
      chk({wtag, " st_wr_en"}, {17'd0, st_wr_en}, 18'd1);
      chk({wtag, " st_wr_data"}, st_wr_data, v.stored);

      rd(rtag, got);
      chk({rtag, " first read"}, got, v.r0);
      if (v.rn && !v.wn) begin
        rd(rtag, got);
        chk({rtag, " second read"}, got, v.r1);
      end
      chk({rtag, " request count"}, DW'(req_cnt), 18'd1);
    end

    // R9: reset clears a nonzero read register
    do_reset(1'b0, 1'b0, 1'b0);
    chk("R9 rd_data cleared", rd_data, '0);

    // R5: pending half discarded by reset
    do_reset(1'b1, 1'b0, 1'b0);
    wr(18'h000AA);
    do_reset(1'b1, 1'b0, 1'b0);
    wr(18'h00011);
    chk("R5 no word after one half", {17'd0, st_wr_en}, 18'd0);
    wr(18'h00022);
    chk("R5 fresh pair", st_wr_data, 18'h02222);

    // R1: configuration inputs changed after reset are ignored
    do_reset(1'b1, 1'b0, 1'b1);
    cfg_wr_narrow = 1'b0; cfg_rd_narrow = 1'b1; cfg_little = 1'b0;
    wr(18'h00003);
    chk("R1 still packing", {17'd0, st_wr_en}, 18'd0);
    wr(18'h00100);
    chk("R1 still little", st_wr_data, 18'h20003);
    rd("R1", got);
    chk("R1 still wide read", got, 18'h20003);

    // R7: two unpacked words back to back, big-endian
    do_reset(1'b0, 1'b1, 1'b0);
    wr(18'h3FE01);
    wr(18'h00403);
    rd("R7", got); chk("R7 word0 hi", got, 18'h001FF);
    rd("R7", got); chk("R7 word0 lo", got, 18'h00001);
    rd("R7", got); chk("R7 word1 hi", got, 18'h00002);
    rd("R7", got); chk("R7 word1 lo", got, 18'h00003);
    chk("R7 two requests", DW'(req_cnt), 18'd2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule